// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Periodic Rate Unit

This block holds the interrupt-status state of a PC-style real-time clock. Three event sources feed it: a periodic event made locally from a 32.768 kHz reference tick, and alarm-match and update-ended events that arrive from the surrounding clock logic as single-cycle strobes. Each source owns one flag that latches whenever its event occurs, whether or not the source is enabled. A control register holds one enable per source, at the same bit position as that source's flag. A summary bit and the interrupt output are high only while at least one enabled flag is set.

Software reaches the block through a byte-wide register port in which the address is the register index. Index 0 holds a 4-bit logarithmic rate code for the periodic event. Index 1 holds the enables. Index 2 is the flag register. Reading the flag register returns the flags and the summary bit and clears all of them, which also releases the interrupt line. If an event strobe lands in the same cycle as that read, it is not lost. Writing the rate code restarts the periodic divider.

Top module: `rtc_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, the rate register (index 0) reads 0x06, the control register (index 1) reads 0x00, the flag register (index 2) reads 0x00, and irq is low.
- R2: A one-cycle strobe on update_evt, on alarm_evt, or a periodic event sets the flag bit at position 4, 5 or 6 respectively in the flag register. This happens even while the matching enable is clear, and irq then stays low.
- R3: The control register keeps the enables for update, alarm and periodic at bits 4, 5 and 6. irq and flag-register bit 7 are high exactly when some flag AND its enable is nonzero, including when an enable is set after its flag.
- R4: rdata shows the addressed register combinationally. A read (rd_en high) at index 2 returns {bit7 summary, bit6 periodic, bit5 alarm, bit4 update, bits 3:0 zero}, and every flag is clear from the next cycle on.
- R5: When an event strobe arrives in the same cycle as a flag-register read, that read returns the old flags and the event's flag is set after the clear.
- R6: A rate code n from 1 to 15 produces a periodic event every 2^(n-1) reference ticks, which is 2^(16-n) Hz from a 32.768 kHz tick. The reset code 6 gives one event every 32 ticks.
- R7: Rate code 0 produces no periodic event however many ticks arrive.
- R8: Writing the rate register restarts the divider. The first periodic event at the new code comes on the 2^(n-1)-th tick after the write.
- R9: Once set, a flag and the irq level it drives stay set until the flag register is read. A write to index 2 has no effect on them.
- R10: The rate register reads its code in bits 3:0 with bits 7:4 zero. The control register reads only bits 6:4, with every other bit zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per 32.768 kHz reference period |
| alarm_evt | input | 1 | One-cycle alarm-match strobe |
| update_evt | input | 1 | One-cycle update-ended strobe |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a read of index 2 clears the flags) |
| addr | input | 2 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Data of the addressed register |
| irq | output | 1 | Interrupt request level |

## Verification
The bench builds the block with its default 4-bit rate field, which gives rate codes 0 to 15 and a divider of up to 16384 ticks. Because the bench drives the reference tick itself, a tick every other clock cycle, even the slowest code (one event per 16384 ticks) completes within the run. This measures the period exactly at code 1, at the reset code, at a middle code and at that top code. The same default build brings within reach a rate rewrite partway through a period, a strobe colliding with a clearing read, and flags raised while masked.

// File: rtl/rtc_irq_pkg.sv
// Shared constants for the RTC interrupt flag and rate unit.
// Assumes an 8-bit register port and three event sources whose flag and
// enable bits share positions, so one mask serves both registers.
package rtc_irq_pkg;
    localparam int REG_AW  = 2;
    localparam int DATA_W  = 8;
    localparam int RATE_W  = 4;
    localparam int NUM_SRC = 3;

    // Register indices seen on addr
    localparam logic [REG_AW-1:0] IDX_RATE = 2'd0;
    localparam logic [REG_AW-1:0] IDX_CTRL = 2'd1;
    localparam logic [REG_AW-1:0] IDX_FLAG = 2'd2;

    // Source i (0 update, 1 alarm, 2 periodic) sits at bit SRC_LSB + i
    localparam int SRC_LSB = 4;
    localparam int BIT_SUM = 7;

    localparam logic [RATE_W-1:0] RATE_RESET = 4'd6;
endpackage

// File: rtl/rtc_rate_div.sv
// Periodic event divider. Counts reference ticks and emits a one-cycle
// event every 2^(code-1) ticks. Code 0 holds the counter idle. A restart
// strobe (rate rewrite) zeroes the counter and suppresses any event in
// that cycle. Assumes the code changes only together with restart.
module rtc_rate_div #(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [RATE_W-1:0] code,
    input  logic              restart,
    output logic              per_evt
);
    localparam int CNT_W = (1 << RATE_W) - 2;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             code_on;
    logic             at_limit;

    // Terminal count for the current code: 2^(code-1) - 1
    always_comb begin
        code_on = (code != '0);
        limit   = '0;
        if (code_on) begin
            limit = CNT_W'((1 << (int'(code) - 1)) - 1);
        end
        at_limit = (cnt_q == limit);
        per_evt  = ref_tick && code_on && at_limit && !restart;
    end

    // Tick counter with restart and wrap at the terminal count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !code_on) begin
            cnt_q <= '0;
        end else if (ref_tick) begin
            cnt_q <= at_limit ? '0 : cnt_q + 1'b1;
        end
    end

    // R8: a restart leaves the counter at zero in the next cycle
    assert_restart_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R6: the counter never runs past the terminal count of the live code
    assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);
endmodule

// File: rtl/rtc_flag_bank.sv
// Event flag bank. Each flag latches on its event strobe regardless of
// its enable and holds until a clearing read. An event in the same cycle
// as the clear survives it. The summary is the OR of flags masked by the
// enables.
module rtc_flag_bank #(
    parameter int NUM_SRC = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] events,
    input  logic [NUM_SRC-1:0] enables,
    input  logic               rd_clear,
    output logic [NUM_SRC-1:0] flags,
    output logic               summary
);
    // Latch events on top of the held (or just cleared) flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= '0;
        end else begin
            flags <= (rd_clear ? '0 : flags) | events;
        end
    end

    // Masked request summary
    always_comb begin
        summary = |(flags & enables);
    end

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_chk
            // R2, R5: an event always leaves its flag set next cycle
            assert_flag_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
                events[i] |=> flags[i]);
        end
    endgenerate

    // R4: a clearing read with no event empties the bank
    assert_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clear && (events == '0)) |=> (flags == '0));

    // R9: without a clearing read no set flag drops
    assert_flag_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clear |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/rtc_reg_port.sv
// Register port. Holds the rate code and the enables, decodes write and
// read strobes by index, and returns the addressed register on rdata
// combinationally. A write to the rate index issues a divider restart,
// and a read of the flag index issues the flag clear. Writes to the flag
// index are dropped.
module rtc_reg_port
    import rtc_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [REG_AW-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [DATA_W-1:0]  flag_view,
    output logic [RATE_W-1:0]  rate_code,
    output logic [NUM_SRC-1:0] enables,
    output logic               rate_restart,
    output logic               flag_rd_clear,
    output logic [DATA_W-1:0]  rdata
);
    logic wr_ctrl;

    // Index decode of the access strobes
    always_comb begin
        rate_restart  = wr_en && (addr == IDX_RATE);
        wr_ctrl       = wr_en && (addr == IDX_CTRL);
        flag_rd_clear = rd_en && (addr == IDX_FLAG);
    end

    // Rate code register, reset to the 1024 Hz code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_code <= RATE_RESET;
        end else if (rate_restart) begin
            rate_code <= wdata[RATE_W-1:0];
        end
    end

    // Enable register, one bit per source at the flag positions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enables <= '0;
        end else if (wr_ctrl) begin
            enables <= wdata[SRC_LSB +: NUM_SRC];
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            IDX_RATE: rdata[RATE_W-1:0]         = rate_code;
            IDX_CTRL: rdata[SRC_LSB +: NUM_SRC] = enables;
            IDX_FLAG: rdata                     = flag_view;
            default:  rdata                     = '0;
        endcase
    end

    // R10: the rate code changes only through a rate write
    assert_rate_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rate_restart |=> $stable(rate_code));

    // R3: the enables change only through a control write
    assert_enable_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(enables));
endmodule

// File: rtl/rtc_irq_unit.sv
// Top of the RTC interrupt flag and rate unit. Joins the register port,
// the periodic divider and the flag bank, packs the flag register view
// and drives the interrupt level from the masked summary. Assumes the
// alarm and update strobes are one cycle wide and synchronous to clk.
module rtc_irq_unit
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              alarm_evt,
    input  logic              update_evt,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [RATE_W-1:0]  rate_code;
    logic [NUM_SRC-1:0] enables;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] events;
    logic [DATA_W-1:0]  flag_view;
    logic               rate_restart;
    logic               flag_rd_clear;
    logic               per_evt;
    logic               summary;

    rtc_reg_port u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .addr          (addr),
        .wdata         (wdata),
        .flag_view     (flag_view),
        .rate_code     (rate_code),
        .enables       (enables),
        .rate_restart  (rate_restart),
        .flag_rd_clear (flag_rd_clear),
        .rdata         (rdata)
    );

    rtc_rate_div #(.RATE_W(RATE_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .code     (rate_code),
        .restart  (rate_restart),
        .per_evt  (per_evt)
    );

    // Event vector in source order: update, alarm, periodic
    always_comb begin
        events = {per_evt, alarm_evt, update_evt};
    end

    rtc_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .events   (events),
        .enables  (enables),
        .rd_clear (flag_rd_clear),
        .flags    (flags),
        .summary  (summary)
    );

    // Pack summary and flags into the flag register layout
    always_comb begin
        flag_view          = '0;
        flag_view[BIT_SUM] = summary;
        for (int i = 0; i < NUM_SRC; i++) begin
            flag_view[SRC_LSB + i] = flags[i];
        end
    end

    // Interrupt level follows the masked summary
    always_comb begin
        irq = summary;
    end

    // R9, R3: irq only drops after a flag read or an enable write
    assert_irq_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> ($past(rd_en && (addr == IDX_FLAG)) ||
                        $past(wr_en && (addr == IDX_CTRL))));
endmodule

// File: tb/rtc_irq_unit_test.sv
// Directed bench for the RTC interrupt flag and rate unit.
module rtc_irq_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       alarm_evt = 1'b0;
    logic       update_evt = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    rtc_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .alarm_evt(alarm_evt), .update_evt(update_evt),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Read with side effect; returns the value seen during the strobe
    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Look at a register without strobing rd_en
    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        ref_tick = 1'b1;
        @(negedge clk);
        ref_tick = 1'b0;
    endtask

    task automatic pulse_alarm();
        @(negedge clk);
        alarm_evt = 1'b1;
        @(negedge clk);
        alarm_evt = 1'b0;
    endtask

    task automatic pulse_update();
        @(negedge clk);
        update_evt = 1'b1;
        @(negedge clk);
        update_evt = 1'b0;
    endtask

    // Ticks until irq rises (periodic enabled only); 0 if never
    task automatic measure(input int limit, output int n);
        n = 0;
        for (int i = 1; i <= limit; i++) begin
            tick();
            if (irq) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        peek(2'd0, d); check("R1", d, 8'h06, "rate after reset");
        peek(2'd1, d); check("R1", d, 8'h00, "ctrl after reset");
        peek(2'd2, d); check("R1", d, 8'h00, "flags after reset");
        check("R1", irq, 0, "irq after reset");
    endtask

    task automatic t_rate_default();
        logic [7:0] d;
        int n;
        wr(2'd1, 8'h40);
        measure(100, n);
        check("R6", n, 32, "ticks per event at reset code 6");
        rd(2'd2, d);
        check("R4", d, 8'hC0, "periodic flag read");
        check("R4", irq, 0, "irq after clearing read");
        wr(2'd1, 8'h00);
    endtask

    task automatic t_latch_masked();
        logic [7:0] d;
        pulse_update();
        check("R2", irq, 0, "irq with masked update flag");
        rd(2'd2, d);
        check("R2", d, 8'h10, "masked update flag latched");
        peek(2'd2, d);
        check("R4", d, 8'h00, "flags clear after read");
    endtask

    task automatic t_enable_summary();
        logic [7:0] d;
        wr(2'd1, 8'h20);
        pulse_update();
        check("R3", irq, 0, "irq with only update flag, alarm enabled");
        pulse_alarm();
        check("R3", irq, 1, "irq with enabled alarm flag");
        rd(2'd2, d);
        check("R3", d, 8'hB0, "summary with alarm and update flags");
        check("R4", irq, 0, "irq released by read");
        wr(2'd1, 8'h00);
        pulse_alarm();
        check("R2", irq, 0, "irq with masked alarm flag");
        wr(2'd1, 8'h20);
        check("R3", irq, 1, "irq rises when enable set after flag");
        rd(2'd2, d);
        check("R3", d, 8'hA0, "late-enabled alarm read");
    endtask

    task automatic t_collision();
        logic [7:0] d;
        pulse_update();
        @(negedge clk);
        rd_en = 1'b1; addr = 2'd2; alarm_evt = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0; alarm_evt = 1'b0;
        check("R5", d, 8'h10, "read in collision cycle returns old flags");
        check("R5", irq, 1, "irq from colliding alarm");
        rd(2'd2, d);
        check("R5", d, 8'hA0, "alarm set after clear");
    endtask

    task automatic t_hold_and_ignore();
        logic [7:0] d;
        pulse_alarm();
        wr(2'd2, 8'h00);
        repeat (5) @(negedge clk);
        check("R9", irq, 1, "irq held after flag write");
        rd(2'd2, d);
        check("R9", d, 8'hA0, "flags kept after flag write");
        wr(2'd1, 8'h00);
    endtask

    task automatic t_rate_codes();
        logic [7:0] d;
        int n;
        wr(2'd1, 8'h40);
        wr(2'd0, 8'h01); rd(2'd2, d);
        measure(10, n); check("R6", n, 1, "ticks per event at code 1");
        wr(2'd0, 8'h03); rd(2'd2, d);
        measure(20, n); check("R6", n, 4, "ticks per event at code 3");
        wr(2'd0, 8'h0F); rd(2'd2, d);
        measure(20000, n); check("R6", n, 16384, "ticks per event at code 15");
        rd(2'd2, d);
    endtask

    task automatic t_rate_off();
        logic [7:0] d;
        int n;
        wr(2'd0, 8'h00); rd(2'd2, d);
        measure(200, n); check("R7", n, 0, "no periodic event at code 0");
        rd(2'd2, d); check("R7", d, 8'h00, "periodic flag clear at code 0");
    endtask

    task automatic t_restart();
        logic [7:0] d;
        int n;
        wr(2'd0, 8'h03); rd(2'd2, d);
        tick(); tick();
        check("R8", irq, 0, "no event after 2 of 4 ticks");
        wr(2'd0, 8'h03);
        measure(20, n);
        check("R8", n, 4, "full period after rate rewrite");
        rd(2'd2, d);
        wr(2'd1, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] d;
        wr(2'd0, 8'hFA); peek(2'd0, d);
        check("R10", d, 8'h0A, "rate readback masks upper bits");
        wr(2'd1, 8'hFF); peek(2'd1, d);
        check("R10", d, 8'h70, "ctrl readback only bits 6:4");
        wr(2'd1, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rate_default();
        t_latch_masked();
        t_enable_summary();
        t_collision();
        t_hold_and_ignore();
        t_rate_codes();
        t_rate_off();
        t_restart();
        t_readback();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule